// File: doc/BRIEF.md
# Debug Serial Mailbox Register Bank

This block connects a debugger's word-wide register bus to a small number of character channels that lead into a processor core. Each channel has two FIFOs. The debugger fills the downstream FIFO, which the core drains. The core fills the upstream FIFO, which the debugger drains. The channel count and the FIFO depth are fixed when the block is built.

The debugger sees three registers: control/status at address 0x34, transmit data at 0x35 and receive data at 0x36. A select field in the control/status register picks the channel that the two data registers act on. Each channel has a sticky error bit. Any blocked debugger transfer sets it, and while it is set it blocks all further data transfers on that channel. A blocked transfer also raises a bus error in the same cycle.

On the core side each FIFO has a push or pop handshake. A core transfer that cannot complete is dropped. It is reported on a per-channel fault output and does not touch the debugger error bit. Bus responses are combinational: `bus_rdata` and `bus_err` are valid in the cycle `bus_req` is high, and state changes at the next rising clock edge.

Top module: `dbg_serial_mbox`

## Requirements
- R1: After reset the control/status register reads select 0, all channel flags 0 and the channel count in bits [7:4]. The transmit register reads 0.
- R2: Control/status layout: select in bits [1:0], channel count in bits [7:4]. For channel c: error at bit 8+3c, upstream-not-empty at bit 9+3c, downstream-full at bit 10+3c. Accesses to any address other than 0x34, 0x35 and 0x36 read 0 and never raise `bus_err`. Control/status accesses never raise `bus_err`.
- R3: A control/status write loads select from bits [1:0] only when that value is below the channel count. Otherwise select keeps its value.
- R4: A transmit write to the selected channel enqueues the data when that channel's error bit is clear and its downstream FIFO is not full. No bus error is raised. The core receives the entries in write order on `core_d2c_data`, qualified by `core_d2c_valid`.
- R5: A transmit write to a channel whose downstream FIFO is full, or whose error bit is set, enqueues nothing. It raises `bus_err` in that cycle and leaves the error bit set from the next cycle on.
- R6: A transmit read returns the data of the most recent transmit write, accepted or rejected. It raises no error and changes no state.
- R7: A receive read with the error bit clear and the upstream FIFO not empty returns the oldest entry in that cycle, removes it, and raises no error.
- R8: A receive read with the upstream FIFO empty, or with the error bit set, returns 0. It raises `bus_err`, sets the error bit and leaves the FIFO untouched.
- R9: A set error bit stays set until a control/status write carries 1 in that channel's error bit position. A 0 in that position, or a 1 in another channel's position, leaves it set.
- R10: The upstream-not-empty flag equals "upstream FIFO holds at least one entry". The downstream-full flag equals "downstream FIFO holds DEPTH entries".
- R11: Writes to the receive register change no state and raise no bus error.
- R12: A core push into a full upstream FIFO, or a core pop from an empty downstream FIFO, is dropped. `core_fault` for that channel is high in the same cycle, and the debugger error bits do not change. A core transfer and a debugger transfer on the same FIFO in one cycle both complete whenever each is allowed by the FIFO state before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req | input | 1 | Debugger register access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle |
| bus_err | output | 1 | Access failed, same cycle |
| core_d2c_pop | input | NCH | Core pops downstream FIFO, per channel |
| core_d2c_data | output | NCH*32 | Head entry of each downstream FIFO |
| core_d2c_valid | output | NCH | Downstream FIFO not empty |
| core_c2d_push | input | NCH | Core pushes upstream FIFO, per channel |
| core_c2d_wdata | input | NCH*32 | Core push data |
| core_c2d_ready | output | NCH | Upstream FIFO not full |
| core_fault | output | NCH | Core transfer dropped this cycle |

## Verification
The bound checker checks properties on every cycle:
- select stays within the channel count;
- rejected transmit and receive accesses raise a bus error and latch the error bit;
- error bits stay set until an explicit clear;
- a full flag holds while the core does not pop;
- dropped core transfers raise the fault output.

Only the bench's reference model can show three things: data order through each FIFO, the transmit echo value, and the independence of one channel from another's traffic. It shows them by comparing every output on every cycle across fill, drain, lockout, clear and simultaneous push/pop scenarios.

// File: rtl/dsm_pkg.sv
// Shared constants for the debug serial mailbox: register addresses,
// control/status field placement and the access-type encoding.
package dsm_pkg;
    localparam int unsigned AW = 8;
    localparam int unsigned DW = 32;

    localparam logic [AW-1:0] ADDR_CSR = 8'h34;
    localparam logic [AW-1:0] ADDR_TXD = 8'h35;
    localparam logic [AW-1:0] ADDR_RXD = 8'h36;

    localparam int unsigned SEL_LSB   = 0;
    localparam int unsigned SEL_W     = 2;
    localparam int unsigned CNT_LSB   = 4;
    localparam int unsigned CNT_W     = 4;
    localparam int unsigned CH_BASE   = 8;
    localparam int unsigned CH_STRIDE = 3;
    localparam int unsigned OFS_ERR   = 0;
    localparam int unsigned OFS_VALID = 1;
    localparam int unsigned OFS_FULL  = 2;

    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_CSR,
        ACC_TXD,
        ACC_RXD
    } acc_e;

    // Bit position of a per-channel status field in the control/status word.
    function automatic int unsigned ch_bit(input int unsigned ch, input int unsigned ofs);
        return CH_BASE + CH_STRIDE * ch + ofs;
    endfunction
endpackage

// File: rtl/dsm_fifo.sv
// Synchronous FIFO with show-ahead head output.
// Assumes: push while full and pop while empty are dropped here, so callers
// may present requests unconditionally. Push and pop may occur together.
module dsm_fifo #(
    parameter int unsigned WIDTH = 32,
    parameter int unsigned DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic             full,
    output logic             empty
);
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wr_ptr;
    logic [PW-1:0]    rd_ptr;
    logic [CW-1:0]    count;
    logic             do_push;
    logic             do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rd_ptr];

    function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= ptr_next(wr_ptr);
            if (do_pop)  rd_ptr <= ptr_next(rd_ptr);
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    // Storage write; contents need no reset because count gates visibility.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end
endmodule

// File: rtl/dsm_channel.sv
// One mailbox channel: downstream FIFO (debugger to core), upstream FIFO
// (core to debugger), the sticky debugger error bit and the core fault flag.
// Assumes: err_set and err_clr are never high together (distinct registers).
module dsm_channel #(
    parameter int unsigned WIDTH = 32,
    parameter int unsigned DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dbg_push,
    input  logic [WIDTH-1:0] dbg_wdata,
    input  logic             dbg_pop,
    output logic [WIDTH-1:0] dbg_rdata,
    input  logic             err_set,
    input  logic             err_clr,
    output logic             err,
    output logic             d2c_full,
    output logic             c2d_valid,
    input  logic             core_pop,
    output logic [WIDTH-1:0] core_rdata,
    output logic             core_valid,
    input  logic             core_push,
    input  logic [WIDTH-1:0] core_wdata,
    output logic             core_ready,
    output logic             core_fault
);
    logic d2c_empty;
    logic c2d_full;
    logic c2d_empty;

    dsm_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_d2c (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (dbg_push),
        .wdata (dbg_wdata),
        .pop   (core_pop),
        .rdata (core_rdata),
        .full  (d2c_full),
        .empty (d2c_empty)
    );

    dsm_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_c2d (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (core_push),
        .wdata (core_wdata),
        .pop   (dbg_pop),
        .rdata (dbg_rdata),
        .full  (c2d_full),
        .empty (c2d_empty)
    );

    assign core_valid = !d2c_empty;
    assign core_ready = !c2d_full;
    assign c2d_valid  = !c2d_empty;
    assign core_fault = (core_push && c2d_full) || (core_pop && d2c_empty);

    // Sticky error bit: set by a blocked debugger access, cleared by write-1.
    always_ff @(posedge clk) begin
        if (!rst_n)       err <= 1'b0;
        else if (err_set) err <= 1'b1;
        else if (err_clr) err <= 1'b0;
    end
endmodule

// File: rtl/dbg_serial_mbox.sv
// Debug serial mailbox register bank: decodes the debugger register bus,
// keeps the channel select and transmit echo, and routes data accesses to
// the selected channel. Responses are combinational in the request cycle.
// Assumes: 1 <= NCH <= 4 so all status fields fit the control/status word.
module dbg_serial_mbox #(
    parameter int unsigned NCH   = 2,
    parameter int unsigned DEPTH = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_req,
    input  logic                        bus_we,
    input  logic [dsm_pkg::AW-1:0]      bus_addr,
    input  logic [dsm_pkg::DW-1:0]      bus_wdata,
    output logic [dsm_pkg::DW-1:0]      bus_rdata,
    output logic                        bus_err,
    input  logic [NCH-1:0]              core_d2c_pop,
    output logic [NCH*dsm_pkg::DW-1:0]  core_d2c_data,
    output logic [NCH-1:0]              core_d2c_valid,
    input  logic [NCH-1:0]              core_c2d_push,
    input  logic [NCH*dsm_pkg::DW-1:0]  core_c2d_wdata,
    output logic [NCH-1:0]              core_c2d_ready,
    output logic [NCH-1:0]              core_fault
);
    import dsm_pkg::*;

    localparam int unsigned SELW = (NCH > 1) ? $clog2(NCH) : 1;

    acc_e           acc;
    logic [SELW-1:0] sel_q;
    logic [DW-1:0]  tx_last;
    logic [NCH-1:0] ch_err;
    logic [NCH-1:0] ch_full;
    logic [NCH-1:0] ch_valid;
    logic [DW-1:0]  ch_rdata [NCH];
    logic           csr_wr;
    logic           tx_wr;
    logic           rx_rd;
    logic           tx_ok;
    logic           rx_ok;
    logic           blocked;
    logic           sel_err;
    logic [DW-1:0]  csr_view;

    // Address decode into an access type.
    always_comb begin
        acc = ACC_NONE;
        if (bus_req) begin
            unique case (bus_addr)
                ADDR_CSR: acc = ACC_CSR;
                ADDR_TXD: acc = ACC_TXD;
                ADDR_RXD: acc = ACC_RXD;
                default:  acc = ACC_NONE;
            endcase
        end
    end

    assign csr_wr  = (acc == ACC_CSR) && bus_we;
    assign tx_wr   = (acc == ACC_TXD) && bus_we;
    assign rx_rd   = (acc == ACC_RXD) && !bus_we;
    assign sel_err = ch_err[sel_q];
    assign tx_ok   = tx_wr && !sel_err && !ch_full[sel_q];
    assign rx_ok   = rx_rd && !sel_err && ch_valid[sel_q];
    assign blocked = (tx_wr && !tx_ok) || (rx_rd && !rx_ok);
    assign bus_err = blocked;

    // Channel select register; out-of-range values are refused.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else if (csr_wr && (32'(bus_wdata[SEL_LSB +: SEL_W]) < NCH)) begin
            sel_q <= bus_wdata[SEL_LSB +: SELW];
        end
    end

    // Transmit echo: holds the data of the latest transmit write.
    always_ff @(posedge clk) begin
        if (!rst_n)     tx_last <= '0;
        else if (tx_wr) tx_last <= bus_wdata;
    end

    // Per-channel instances and their routing from the decoded access.
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        localparam int unsigned EBIT = ch_bit(c, OFS_ERR);
        logic hit;
        assign hit = (sel_q == SELW'(c));

        dsm_channel #(.WIDTH(DW), .DEPTH(DEPTH)) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .dbg_push   (tx_ok && hit),
            .dbg_wdata  (bus_wdata),
            .dbg_pop    (rx_ok && hit),
            .dbg_rdata  (ch_rdata[c]),
            .err_set    (blocked && hit),
            .err_clr    (csr_wr && bus_wdata[EBIT]),
            .err        (ch_err[c]),
            .d2c_full   (ch_full[c]),
            .c2d_valid  (ch_valid[c]),
            .core_pop   (core_d2c_pop[c]),
            .core_rdata (core_d2c_data[c*DW +: DW]),
            .core_valid (core_d2c_valid[c]),
            .core_push  (core_c2d_push[c]),
            .core_wdata (core_c2d_wdata[c*DW +: DW]),
            .core_ready (core_c2d_ready[c]),
            .core_fault (core_fault[c])
        );
    end

    // Assemble the control/status read view.
    always_comb begin
        csr_view = '0;
        csr_view[SEL_LSB +: SEL_W] = SEL_W'(sel_q);
        csr_view[CNT_LSB +: CNT_W] = CNT_W'(NCH);
        for (int c = 0; c < NCH; c++) begin
            csr_view[ch_bit(c, OFS_ERR)]   = ch_err[c];
            csr_view[ch_bit(c, OFS_VALID)] = ch_valid[c];
            csr_view[ch_bit(c, OFS_FULL)]  = ch_full[c];
        end
    end

    // Read data multiplexer; writes and failed reads return zero.
    always_comb begin
        bus_rdata = '0;
        if (!bus_we) begin
            case (acc)
                ACC_CSR: bus_rdata = csr_view;
                ACC_TXD: bus_rdata = tx_last;
                ACC_RXD: bus_rdata = rx_ok ? ch_rdata[sel_q] : '0;
                default: bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/dsm_checker.sv
// Cycle properties of the debug serial mailbox, bound to the top module.
// Assumes visibility of the top's select register and per-channel flags.
module dsm_checker #(
    parameter int unsigned NCH   = 2,
    parameter int unsigned DEPTH = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       bus_req,
    input logic                       bus_we,
    input logic [dsm_pkg::AW-1:0]     bus_addr,
    input logic [dsm_pkg::DW-1:0]     bus_wdata,
    input logic [dsm_pkg::DW-1:0]     bus_rdata,
    input logic                       bus_err,
    input logic [NCH-1:0]             core_d2c_pop,
    input logic [NCH-1:0]             core_c2d_push,
    input logic [NCH-1:0]             core_c2d_ready,
    input logic [NCH-1:0]             core_fault,
    input logic [((NCH > 1) ? $clog2(NCH) : 1)-1:0] sel_q,
    input logic [NCH-1:0]             ch_err,
    input logic [NCH-1:0]             ch_full,
    input logic [NCH-1:0]             ch_valid
);
    import dsm_pkg::*;

    logic tx_wr;
    logic rx_rd;
    assign tx_wr = bus_req && bus_we && (bus_addr == ADDR_TXD);
    assign rx_rd = bus_req && !bus_we && (bus_addr == ADDR_RXD);

    p_sel_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        32'(sel_q) < NCH);

    p_csr_no_err_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_addr == ADDR_CSR) |-> !bus_err);

    p_tx_reject_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wr && (ch_err[sel_q] || ch_full[sel_q])) |-> bus_err);

    p_tx_err_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wr && ch_full[sel_q]) |=> ch_err[$past(sel_q)]);

    p_rx_reject_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_rd && (ch_err[sel_q] || !ch_valid[sel_q])) |-> (bus_err && bus_rdata == '0));

    p_rxd_write_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we && bus_addr == ADDR_RXD) |-> !bus_err);

    for (genvar c = 0; c < NCH; c++) begin : g_chk
        localparam int unsigned EBIT = ch_bit(c, OFS_ERR);

        p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_err[c] && !(bus_req && bus_we && bus_addr == ADDR_CSR && bus_wdata[EBIT]))
            |=> ch_err[c]);

        p_full_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_full[c] && !core_d2c_pop[c]) |=> ch_full[c]);

        p_core_fault_r12: assert property (@(posedge clk) disable iff (!rst_n)
            (core_c2d_push[c] && !core_c2d_ready[c]) |-> core_fault[c]);
    end
endmodule

bind dbg_serial_mbox dsm_checker #(.NCH(NCH), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/sim_dbg_serial_mbox.sv
// Bench: behavioural reference model (queues) compared on every clock.
module sim_dbg_serial_mbox;
    localparam int NCH   = 2;
    localparam int DEPTH = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_req = 1'b0;
    logic              bus_we = 1'b0;
    logic [7:0]        bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              bus_err;
    logic [NCH-1:0]    c_pop = '0;
    logic [NCH*32-1:0] core_d2c_data;
    logic [NCH-1:0]    core_d2c_valid;
    logic [NCH-1:0]    c_push = '0;
    logic [NCH*32-1:0] c_wdata = '0;
    logic [NCH-1:0]    core_c2d_ready;
    logic [NCH-1:0]    core_fault;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0]    q_d2c [NCH][$];
    logic [31:0]    q_c2d [NCH][$];
    logic [NCH-1:0] m_err = '0;
    int             m_sel = 0;
    logic [31:0]    m_tx = '0;

    always #2 clk = ~clk;

    dbg_serial_mbox #(.NCH(NCH), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_err(bus_err), .core_d2c_pop(c_pop), .core_d2c_data(core_d2c_data),
        .core_d2c_valid(core_d2c_valid), .core_c2d_push(c_push),
        .core_c2d_wdata(c_wdata), .core_c2d_ready(core_c2d_ready),
        .core_fault(core_fault)
    );

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] m_csr();
        logic [31:0] v = '0;
        v[1:0] = 2'(m_sel);
        v[7:4] = 4'(NCH);
        for (int c = 0; c < NCH; c++) begin
            v[8 + 3*c]  = m_err[c];
            v[9 + 3*c]  = (q_c2d[c].size() > 0);
            v[10 + 3*c] = (q_d2c[c].size() == DEPTH);
        end
        return v;
    endfunction

    // One clock: compare all outputs against the model, then advance it.
    task automatic cyc(string tag);
        logic [31:0] e_rd;
        logic        e_err;
        int          sd [NCH];
        int          sc [NCH];
        bit          dpush;
        bit          dpop;
        #1;
        e_rd = '0; e_err = 1'b0;
        for (int c = 0; c < NCH; c++) begin
            sd[c] = q_d2c[c].size();
            sc[c] = q_c2d[c].size();
        end
        if (bus_req && !bus_we) begin
            if (bus_addr == 8'h34) e_rd = m_csr();
            else if (bus_addr == 8'h35) e_rd = m_tx;
            else if (bus_addr == 8'h36) begin
                if (!m_err[m_sel] && sc[m_sel] > 0) e_rd = q_c2d[m_sel][0];
                else e_err = 1'b1;
            end
        end
        if (bus_req && bus_we && bus_addr == 8'h35)
            e_err = m_err[m_sel] || (sd[m_sel] == DEPTH);
        chk(tag, "bus_rdata", bus_rdata, e_rd);
        chk(tag, "bus_err", 32'(bus_err), 32'(e_err));
        for (int c = 0; c < NCH; c++) begin
            chk(tag, "d2c_valid", 32'(core_d2c_valid[c]), 32'(sd[c] > 0));
            if (sd[c] > 0) chk(tag, "d2c_data", core_d2c_data[c*32 +: 32], q_d2c[c][0]);
            chk(tag, "c2d_ready", 32'(core_c2d_ready[c]), 32'(sc[c] < DEPTH));
            chk(tag, "core_fault", 32'(core_fault[c]),
                32'((c_push[c] && sc[c] == DEPTH) || (c_pop[c] && sd[c] == 0)));
        end
        @(posedge clk);
        dpush = 1'b0; dpop = 1'b0;
        if (bus_req && bus_we && bus_addr == 8'h34) begin
            if (int'(bus_wdata[1:0]) < NCH) m_sel = int'(bus_wdata[1:0]);
            for (int c = 0; c < NCH; c++) if (bus_wdata[8 + 3*c]) m_err[c] = 1'b0;
        end
        if (bus_req && bus_we && bus_addr == 8'h35) begin
            m_tx = bus_wdata;
            if (!m_err[m_sel] && sd[m_sel] < DEPTH) dpush = 1'b1;
            else m_err[m_sel] = 1'b1;
        end
        if (bus_req && !bus_we && bus_addr == 8'h36) begin
            if (!m_err[m_sel] && sc[m_sel] > 0) dpop = 1'b1;
            else m_err[m_sel] = 1'b1;
        end
        for (int c = 0; c < NCH; c++) begin
            if (c_pop[c] && sd[c] > 0) void'(q_d2c[c].pop_front());
            if (c_push[c] && sc[c] < DEPTH) q_c2d[c].push_back(c_wdata[c*32 +: 32]);
        end
        if (dpush) q_d2c[m_sel].push_back(bus_wdata);
        if (dpop)  void'(q_c2d[m_sel].pop_front());
        @(negedge clk);
    endtask

    task automatic bus(bit we, logic [7:0] a, logic [31:0] d, string tag);
        bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
        cyc(tag);
        bus_req = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    endtask

    task automatic cpush(int c, logic [31:0] d, string tag);
        c_push[c] = 1'b1; c_wdata[c*32 +: 32] = d;
        cyc(tag);
        c_push = '0;
    endtask

    task automatic cpop(int c, string tag);
        c_pop[c] = 1'b1;
        cyc(tag);
        c_pop = '0;
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state of control/status and transmit echo
        bus(0, 8'h34, 0, "R1");
        bus(0, 8'h35, 0, "R1");
        // R2: unmapped addresses read zero without error
        bus(0, 8'h33, 0, "R2");
        bus(0, 8'h37, 0, "R2");
        bus(1, 8'h00, 32'hffff_ffff, "R2");
        bus(0, 8'h34, 0, "R2");
        // R3: select in range loads, out of range is refused
        bus(1, 8'h34, 1, "R3");
        bus(0, 8'h34, 0, "R3");
        bus(1, 8'h34, 3, "R3");
        bus(0, 8'h34, 0, "R3");
        bus(1, 8'h34, 0, "R3");
        // R4: enqueue three words, core drains them in order
        bus(1, 8'h35, 32'h11, "R4");
        bus(1, 8'h35, 32'h22, "R4");
        bus(1, 8'h35, 32'h33, "R4");
        cpop(0, "R4"); cpop(0, "R4"); cpop(0, "R4");
        // R10 and R5: fill to DEPTH, overflow write locks out
        for (int i = 0; i < DEPTH; i++) bus(1, 8'h35, 32'ha0 + i, "R10");
        bus(0, 8'h34, 0, "R10");
        bus(1, 8'h35, 32'hbad0, "R5");
        bus(0, 8'h34, 0, "R5");
        // R6: echo returns last written value, even a rejected one
        bus(0, 8'h35, 0, "R6");
        cpop(0, "R5");
        bus(1, 8'h35, 32'hbad1, "R5");
        // R9: zero does not clear, other channel bit does not clear, own bit does
        bus(1, 8'h34, 0, "R9");
        bus(1, 8'h34, 32'h0000_0800, "R9");
        bus(0, 8'h34, 0, "R9");
        bus(1, 8'h34, 32'h0000_0100, "R9");
        bus(1, 8'h35, 32'h77, "R4");
        cpop(0, "R4"); cpop(0, "R4"); cpop(0, "R4"); cpop(0, "R4");
        // R12: pop from empty downstream is dropped and flagged
        cpop(0, "R12");
        bus(0, 8'h34, 0, "R12");
        // R7: core fills channel 1 upstream, debugger reads oldest first
        bus(1, 8'h34, 1, "R7");
        cpush(1, 32'hc1, "R7");
        cpush(1, 32'hc2, "R7");
        bus(0, 8'h36, 0, "R7");
        // R11: write to receive register leaves state alone
        bus(1, 8'h36, 32'hdead, "R11");
        bus(0, 8'h34, 0, "R11");
        bus(0, 8'h36, 0, "R7");
        // R8: read from empty sets error, then lockout with data present
        bus(0, 8'h36, 0, "R8");
        cpush(1, 32'hc3, "R8");
        bus(0, 8'h36, 0, "R8");
        bus(0, 8'h34, 0, "R8");
        bus(1, 8'h34, 32'h0000_0801, "R9");
        bus(0, 8'h36, 0, "R7");
        // R12: push into full upstream is dropped, error bits unchanged
        for (int i = 0; i < DEPTH + 1; i++) cpush(1, 32'hd0 + i, "R12");
        bus(0, 8'h34, 0, "R12");
        // R12: debugger pop and core push together while full and after
        c_push[1] = 1'b1; c_wdata[63:32] = 32'he1;
        bus(0, 8'h36, 0, "R12");
        c_push[1] = 1'b1; c_wdata[63:32] = 32'he2;
        bus(0, 8'h36, 0, "R12");
        c_push = '0;
        for (int i = 0; i < DEPTH; i++) bus(0, 8'h36, 0, "R7");
        // R4: both channels active together, channel 0 unaffected by 1
        bus(1, 8'h34, 0, "R4");
        c_push[1] = 1'b1; c_wdata[63:32] = 32'hf1;
        bus(1, 8'h35, 32'h55, "R4");
        c_push = '0;
        c_pop[0] = 1'b1;
        bus(1, 8'h35, 32'h66, "R4");
        c_pop = '0;
        bus(0, 8'h34, 0, "R10");
        cpop(0, "R4");
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule